// File: doc/BRIEF.md
# Received Frame Destination Filter

This block sits between the serial-port framer of a 2.4 GHz packet radio and an output word FIFO. The radio keeps writing whatever it hears into its receive FIFO, including traffic from other networks and from neighbouring channels. The filter drains that FIFO one byte at a time and keeps only the frames meant for this node. A single status input tells the filter whether the radio FIFO holds data, and the filter never asks for a byte while that input is low.

Each frame starts with a length byte, followed by a destination byte. The filter compares the destination with two programmable node addresses and with the broadcast address. For a kept frame it packs the payload into 32-bit words and pushes them outward. For a dropped frame it reads the same number of bytes and throws them away. A length byte that cannot be valid makes the filter ask the framer to flush the radio FIFO. The filter then waits until the FIFO reports empty, and after that it looks for a new length byte.

Top module: `rx_addr_filter`

## Requirements
- R1: While `rst_ni` is low, `rd_req_o`, `cs_o`, `flush_o` and `out_push_o` are all low.
- R2: A one-cycle `rd_req_o` is raised only when `fifo_nempty_i` was high at the deciding clock edge. At most one byte is outstanding, so no new request is raised until `rd_valid_i` has returned the previous byte.
- R3: The first byte of every frame is its length L, which counts the bytes that follow it. If L is 0 or above 127, the block raises `flush_o` for exactly one cycle. It then raises no request until it has seen `fifo_nempty_i` low, and after that it treats the next byte as a length byte.
- R4: The byte right after the length byte is the destination. The frame is kept when the destination is 0xFF, or when it is nonzero and equals `node_addr0_i` or `node_addr1_i`. A destination of 0 is never kept, even when a node address is programmed to 0.
- R5: A dropped frame causes no push, but exactly L bytes after its length byte are still read. The byte that follows them is treated as the next length byte.
- R6: In a kept frame, the L-3 bytes after the destination are payload, and the last two bytes form a trailer that is discarded. A frame with L of 3 or less pushes nothing.
- R7: Payload is packed most-significant byte first. Payload byte k of a word lands in bits [31-8k -: 8]. A final partial word is pushed with zeros in its unused low bytes. Each push is a one-cycle `out_push_o` with the word on `out_word_o`.
- R8: No request is raised at an edge where `out_full_i` is high, so the output FIFO never overflows. While `out_full_i` is high and no byte is outstanding, `cs_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_addr0_i | input | 8 | First node address |
| node_addr1_i | input | 8 | Second node address |
| fifo_nempty_i | input | 1 | Radio receive FIFO holds data |
| rd_req_o | output | 1 | One-cycle request to the framer for one byte |
| cs_o | output | 1 | Chip select held by the filter during a frame |
| rd_valid_i | input | 1 | Framer returns the requested byte |
| rd_byte_i | input | 8 | Returned byte |
| flush_o | output | 1 | One-cycle request to flush the radio FIFO |
| out_full_i | input | 1 | Output word FIFO is full |
| out_push_o | output | 1 | Push strobe for the output FIFO |
| out_word_o | output | 32 | Packed payload word |

## Verification
The assertions check the following on every cycle: requests never go out against an empty or stale-empty FIFO status, requests never follow each other back to back, no request is made against a full output FIFO, chip select drops while paused, the flush is a single pulse, and a zero destination is never kept while broadcast always is. The packed word values, the zero padding, the trailer drop, byte-exact consumption of dropped frames, and recovery after a flush all depend on whole frames. Only the bench scenarios can show these: directed boundary lengths, node address set to zero, a stalled output, and a run of random mixed traffic.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  typedef enum logic [2:0] {
    ST_LEN,
    ST_DEST,
    ST_BODY,
    ST_FLUSH,
    ST_DRAIN
  } frame_st_e;
endpackage

// File: rtl/rx_rd_seq.sv
module rx_rd_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fetch_en_i,
  input  logic hold_i,
  input  logic fifo_nempty_i,
  input  logic out_full_i,
  input  logic rd_valid_i,
  output logic rd_req_o,
  output logic cs_o
);
  logic req_q, pend_q, req_d;

  assign req_d = fetch_en_i && fifo_nempty_i && !out_full_i && !pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q <= req_d;
      if (req_d)           pend_q <= 1'b1;
      else if (rd_valid_i) pend_q <= 1'b0;
    end
  end

  assign rd_req_o = req_q;
  // held across a frame, dropped while output is stalled
  assign cs_o = pend_q | (hold_i & ~out_full_i);

  a_r2_req_nempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> $past(fifo_nempty_i));
  a_r2_one_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  a_r8_no_req_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !$past(out_full_i));
  a_r8_cs_paused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_full_i && !pend_q) |-> !cs_o);
endmodule

// File: rtl/rx_word_pack.sv
module rx_word_pack #(
  parameter int BYTES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               byte_v_i,
  input  logic [7:0]         byte_i,
  input  logic               close_i,
  output logic               push_o,
  output logic [8*BYTES-1:0] word_o
);
  localparam int W  = 8 * BYTES;
  localparam int IW = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [W-1:0]  acc_q, acc_ins, word_q;
  logic [IW-1:0] idx_q;
  logic          have_q, push_q;

  always_comb begin
    acc_ins = acc_q;
    for (int k = 0; k < BYTES; k++)
      if (idx_q == IW'(k)) acc_ins[W-1-8*k -: 8] = byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      word_q <= '0;
      idx_q  <= '0;
      have_q <= 1'b0;
      push_q <= 1'b0;
    end else begin
      push_q <= 1'b0;
      if (byte_v_i) begin
        if (idx_q == IW'(BYTES - 1)) begin
          word_q <= acc_ins;
          push_q <= 1'b1;
          acc_q  <= '0;
          idx_q  <= '0;
          have_q <= 1'b0;
        end else begin
          acc_q  <= acc_ins;
          idx_q  <= idx_q + 1'b1;
          have_q <= 1'b1;
        end
      end else if (close_i && have_q) begin
        word_q <= acc_q;  // unused low bytes already zero
        push_q <= 1'b1;
        acc_q  <= '0;
        idx_q  <= '0;
        have_q <= 1'b0;
      end
    end
  end

  assign push_o = push_q;
  assign word_o = word_q;

  a_r7_push_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);
  a_r7_empty_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !have_q |-> (idx_q == '0 && acc_q == '0));
endmodule

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl
  import rx_filt_pkg::*;
#(
  parameter int         MAX_LEN = 127,
  parameter logic [7:0] BCAST   = 8'hFF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] node_addr0_i,
  input  logic [7:0] node_addr1_i,
  input  logic       fifo_nempty_i,
  input  logic       rd_valid_i,
  input  logic [7:0] rd_byte_i,
  output logic       fetch_en_o,
  output logic       hold_o,
  output logic       flush_o,
  output logic       pay_v_o,
  output logic       close_o
);
  localparam int TRAILER = 2;

  frame_st_e  st_q;
  logic [7:0] rem_q;
  logic       keep_q, addr_hit, len_bad;

  assign addr_hit = (rd_byte_i == BCAST) ||
                    ((rd_byte_i != 8'd0) &&
                     ((rd_byte_i == node_addr0_i) || (rd_byte_i == node_addr1_i)));
  assign len_bad  = (rd_byte_i == 8'd0) || (rd_byte_i > 8'(MAX_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_LEN;
      rem_q  <= '0;
      keep_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_LEN: if (rd_valid_i) begin
          if (len_bad) st_q <= ST_FLUSH;
          else begin
            rem_q <= rd_byte_i - 8'd1;
            st_q  <= ST_DEST;
          end
        end
        ST_DEST: if (rd_valid_i) begin
          keep_q <= addr_hit;
          st_q   <= (rem_q == 8'd0) ? ST_LEN : ST_BODY;
        end
        ST_BODY: if (rd_valid_i) begin
          rem_q <= rem_q - 8'd1;
          if (rem_q == 8'd1) st_q <= ST_LEN;
        end
        ST_FLUSH: st_q <= ST_DRAIN;
        ST_DRAIN: if (!fifo_nempty_i) st_q <= ST_LEN;
        default:  st_q <= ST_LEN;
      endcase
    end
  end

  assign fetch_en_o = (st_q == ST_LEN) || (st_q == ST_DEST) || (st_q == ST_BODY);
  assign hold_o     = (st_q == ST_DEST) || (st_q == ST_BODY);
  assign flush_o    = (st_q == ST_FLUSH);
  assign pay_v_o    = (st_q == ST_BODY) && rd_valid_i && keep_q && (rem_q > 8'(TRAILER));
  assign close_o    = (st_q == ST_BODY) && rd_valid_i && (rem_q == 8'd1);

  a_r3_bad_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LEN && rd_valid_i && len_bad) |=> flush_o);
  a_r3_flush_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
  a_r4_zero_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DEST && rd_valid_i && rd_byte_i == 8'd0) |=> !keep_q);
  a_r4_bcast_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DEST && rd_valid_i && rd_byte_i == BCAST) |=> keep_q);
  a_r5_drop_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BODY && !keep_q) |-> !pay_v_o);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int         WORD_BYTES = 4,
  parameter int         MAX_LEN    = 127,
  parameter logic [7:0] BCAST      = 8'hFF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [7:0]              node_addr0_i,
  input  logic [7:0]              node_addr1_i,
  input  logic                    fifo_nempty_i,
  output logic                    rd_req_o,
  output logic                    cs_o,
  input  logic                    rd_valid_i,
  input  logic [7:0]              rd_byte_i,
  output logic                    flush_o,
  input  logic                    out_full_i,
  output logic                    out_push_o,
  output logic [8*WORD_BYTES-1:0] out_word_o
);
  logic fetch_en, hold, pay_v, close_w;

  rx_frame_ctl #(.MAX_LEN(MAX_LEN), .BCAST(BCAST)) u_ctl (
    .clk_i, .rst_ni, .node_addr0_i, .node_addr1_i, .fifo_nempty_i,
    .rd_valid_i, .rd_byte_i,
    .fetch_en_o(fetch_en), .hold_o(hold), .flush_o,
    .pay_v_o(pay_v), .close_o(close_w)
  );

  rx_rd_seq u_seq (
    .clk_i, .rst_ni, .fetch_en_i(fetch_en), .hold_i(hold),
    .fifo_nempty_i, .out_full_i, .rd_valid_i, .rd_req_o, .cs_o
  );

  rx_word_pack #(.BYTES(WORD_BYTES)) u_pack (
    .clk_i, .rst_ni, .byte_v_i(pay_v), .byte_i(rd_byte_i), .close_i(close_w),
    .push_o(out_push_o), .word_o(out_word_o)
  );

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!rd_req_o && !cs_o && !flush_o && !out_push_o));
endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  node_addr0_i = 8'h21, node_addr1_i = 8'h5A;
  logic        fifo_nempty_i = 1'b0, rd_valid_i = 1'b0, out_full_i = 1'b0;
  logic [7:0]  rd_byte_i = 8'h00;
  logic        rd_req_o, cs_o, flush_o, out_push_o;
  logic [31:0] out_word_o;

  rx_addr_filter dut_i (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  logic [7:0]  q [0:16383];
  int qh = 0, qt = 0;
  logic [31:0] expw [0:4095];
  logic [31:0] gotw [0:4095];
  int en = 0, gn = 0, cbase = 0;
  int dly = 0, fl_dly = 0, fl_cnt = 0, oc = 0;
  logic [7:0] pend_b = 8'h00;
  bit consume = 1'b1, done = 1'b0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_keep(logic [7:0] d);
    return (d == 8'hFF) || (d != 8'h00 && (d == node_addr0_i || d == node_addr1_i));
  endfunction

  task automatic push_b(logic [7:0] b);
    q[qt] = b; qt++;
  endtask

  task automatic add_frame(int len, logic [7:0] dest);
    logic [31:0] w; int k; bit kp; logic [7:0] b;
    kp = exp_keep(dest);
    push_b(8'(len)); push_b(dest);
    w = '0; k = 0;
    for (int i = 0; i < len - 1; i++) begin
      b = 8'($urandom);
      push_b(b);
      if (kp && i < len - 3) begin
        w[31-8*k -: 8] = b; k++;
        if (k == 4) begin expw[en] = w; en++; w = '0; k = 0; end
      end
    end
    if (kp && k > 0) begin expw[en] = w; en++; end
  endtask

  // environment: framer, radio FIFO, output FIFO
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        rd_valid_i = 1'b0;
        if (dly > 0) begin
          dly--;
          if (dly == 0) begin rd_valid_i = 1'b1; rd_byte_i = pend_b; end
        end
        if (rd_req_o) begin
          chk(out_full_i == 1'b0, "R8", "request while output full", 1, 0);
          if (qh == qt) chk(1'b0, "R2", "request on empty fifo", 1, 0);
          else begin pend_b = q[qh]; qh++; end
          if (dly != 0 || rd_valid_i) chk(1'b0, "R2", "second outstanding request", 1, 0);
          dly = 1 + int'($urandom % 3);
        end
        if (fl_dly > 0) begin
          if (rd_req_o) chk(1'b0, "R3", "request during flush", 1, 0);
          fl_dly--;
          if (fl_dly == 0) qh = qt;
        end
        if (flush_o) begin fl_cnt++; fl_dly = 3; end
        fifo_nempty_i = (qh != qt);
        if (out_push_o) begin
          if (oc == 4) chk(1'b0, "R8", "output overflow", oc, 3);
          gotw[gn] = out_word_o; gn++; oc++;
        end
        if (consume && oc > 0 && $urandom % 2 == 1) oc--;
        out_full_i = (oc == 4);
      end
    end
  end

  task automatic drain();
    int idle = 0;
    for (int n = 0; n < 40000 && idle < 30; n++) begin
      @(negedge clk_i);
      if (qh == qt && dly == 0 && fl_dly == 0 && !rd_valid_i && !rd_req_o) idle++;
      else idle = 0;
    end
  endtask

  task automatic cmp(string req);
    chk(gn == en, req, "word count", gn, en);
    if (gn == en)
      for (int i = cbase; i < en; i++)
        chk(gotw[i] == expw[i], req, "word value", gotw[i], expw[i]);
    if (gn > en) en = gn; else gn = en;
    cbase = en;
  endtask

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int f0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(!rd_req_o && !cs_o && !flush_o && !out_push_o, "R1", "outputs in reset",
        {rd_req_o, cs_o, flush_o, out_push_o}, 0);
    rst_ni = 1'b1;

    // R7: two full words, then a padded tail from a second address (R4)
    add_frame(11, 8'h21); drain(); cmp("R7");
    add_frame(8, 8'h5A);  drain(); cmp("R7");
    // R4: broadcast kept, foreign dropped, R5 next frame still aligned
    add_frame(9, 8'hFF); add_frame(20, 8'h77); add_frame(10, 8'h21); drain(); cmp("R5");
    // R4: zero destination with a node address programmed to zero
    node_addr0_i = 8'h00;
    add_frame(12, 8'h00); add_frame(7, 8'h5A); drain(); cmp("R4");
    node_addr0_i = 8'h21;
    // R6: short frames push nothing, max length gives 31 words
    add_frame(1, 8'h21); add_frame(2, 8'h21); add_frame(3, 8'hFF); drain(); cmp("R6");
    chk(qh == qt, "R5", "short frames consumed", qt - qh, 0);
    add_frame(127, 8'h5A); drain(); cmp("R6");
    // R3: corrupt lengths flush, then recovery
    f0 = fl_cnt;
    push_b(8'h00); push_b(8'h21); push_b(8'h33); drain();
    chk(fl_cnt == f0 + 1, "R3", "flush on zero length", fl_cnt - f0, 1);
    add_frame(6, 8'h21); drain(); cmp("R3");
    push_b(8'd200); push_b(8'h21); drain();
    chk(fl_cnt == f0 + 2, "R3", "flush on oversize length", fl_cnt - f0, 2);
    add_frame(9, 8'h5A); drain(); cmp("R3");
    // R8: stalled output pauses reads with chip select released
    consume = 1'b0;
    add_frame(43, 8'h21);
    repeat (400) @(negedge clk_i);
    chk(oc == 4, "R8", "output filled", oc, 4);
    chk(qh != qt, "R8", "reading paused", qt - qh, 1);
    chk(!cs_o && !rd_req_o, "R8", "cs released while paused", {cs_o, rd_req_o}, 0);
    consume = 1'b1; drain(); cmp("R8");
    // random mixed traffic
    for (int i = 0; i < 50; i++) begin
      logic [7:0] d;
      case ($urandom % 5)
        0: d = 8'h21; 1: d = 8'h5A; 2: d = 8'hFF; 3: d = 8'h00;
        default: d = 8'($urandom);
      endcase
      add_frame(1 + int'($urandom % 60), d);
    end
    drain(); cmp("R7");
    chk(qh == qt, "R5", "all random traffic consumed", qt - qh, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule